// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Unit

This block watches the status pins of one or two removable-card sockets. It brings every pin into the clock domain and keeps a latched record of pin changes. It raises two kinds of interrupt from that record. Software sees three 32-bit registers through a simple read/write port: the live pin levels, a change register cleared by writing ones, and an enable register. The sockets share all three registers. Socket 0 owns bits 31..16 and socket 1 owns bits 15..0, so a bit of socket 1 sits 16 places below the same bit of socket 0.

Within a socket's 16-bit half, bits 15..8 carry the eight pins. From bit 15 down they are: voltage-sense 1, voltage-sense 2, write-protect, detect 2, detect 1, battery 2, battery 1 and ready. Bits 7..4 hold the ready conditions, in this order: ready low (level), ready high (level), ready rose (edge) and ready fell (edge). Bits 3..0 read zero.

The per-socket card interrupt follows the ready-low level and needs no clearing. The shared status-change interrupt stays high while any enabled source is set.

Top module: `card_status_irq`

## Requirements
- R1: After reset every latched change bit and every enable bit is 0. `sc_irq_o` and `card_irq_o` are low. With all pins low, the change register reads 32'h0080_0080, because only the live ready-low bits are set.
- R2: Address 0 returns the synchronised pin levels in bits 15..8 of each half and zero elsewhere. It reflects a pin change two clocks after the change. Bits 15..14 of a half read together as the voltage-sense field: value 1 marks a 3.3 V-only card and value 2 marks a low-voltage-only card.
- R3: A change on any pin sets that pin's bit (half bits 15..8) in the change register at address 1. A rising ready pin also sets half bit 5, and a falling ready pin sets half bit 4. These bits show three clocks after the pin change.
- R4: A detect-pin change sets its bit only when both detect pins of that socket are equal after the change.
- R5: A write to address 1 clears each latched bit written as 1 in a selected half. Bits written as 0 keep their value. A bit that is set in the same cycle as it is cleared stays set.
- R6: A write to address 2 updates only the halves whose select bit is 1. `bus_hsel[1]` selects bits 31..16 and `bus_hsel[0]` selects bits 15..0.
- R7: `sc_irq_o` is the OR over all bits of the change register ANDed with the enable register. The two ready-low bits (23 and 7) are left out of this OR. The output stays high until software clears or disables the source.
- R8: Half bits 7 and 6 of the change register show the live ready-low and ready-high levels, and writes to them have no effect. `card_irq_o[s]` is high while socket s's synchronised ready pin is low and its ready-low enable bit is 1.
- R9: `card_present_o[s]` is high exactly when both synchronised detect pins of socket s are low.
- R10: Address 3 reads zero. Writes to address 0 and address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sock_pins_i | input | NUM_SOCK*8 | Raw pins. Socket s uses bits 8s+7..8s: VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY from the top bit down |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 pins, 1 change, 2 enable |
| bus_hsel | input | 2 | Half select for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sc_irq_o | output | 1 | Shared status-change interrupt |
| card_irq_o | output | NUM_SOCK | Per-socket ready-low card interrupt |
| card_present_o | output | NUM_SOCK | Per-socket card present |

## Verification
A pin change reaches the pin register, `card_irq_o` and `card_present_o` after two clock edges. It reaches the change register and `sc_irq_o` after three edges. A register write takes effect at the single edge that follows the strobe. The bench drives inputs on falling edges, waits four rising edges after every pin change, and reads results one nanosecond after a falling edge. Every result is therefore sampled once it has settled. One directed case places a clearing write on exactly the third edge after a pin change, to show that the setting edge wins over the clear.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int REG_W         = 32;
    localparam int HALF_W        = 16;
    localparam int PINS_PER_SOCK = 8;
    localparam int MAX_SOCK      = REG_W / HALF_W;

    // pin index within a socket's 8-bit pin group
    localparam int P_RDY  = 0;
    localparam int P_CD1  = 3;
    localparam int P_CD2  = 4;

    // bit positions inside a 16-bit half
    localparam int B_PIN   = 8;
    localparam int B_RLOW  = 7;
    localparam int B_RHIGH = 6;
    localparam int B_RRISE = 5;
    localparam int B_RFALL = 4;

    localparam logic [HALF_W-1:0] HALF_LATCH = 16'hFF30;
    localparam logic [HALF_W-1:0] HALF_LOW   = 16'h0080;

    typedef enum logic [1:0] {
        A_PINS = 2'd0,
        A_STAT = 2'd1,
        A_EN   = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/csi_sock_events.sv
module csi_sock_events
    import csi_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PINS_PER_SOCK-1:0] pins_i,
    output logic [HALF_W-1:0]        set_o,
    output logic [HALF_W-1:0]        live_o,
    output logic [HALF_W-1:0]        pinview_o,
    output logic                     present_o,
    output logic                     rdy_low_o
);
    typedef struct packed {
        logic [PINS_PER_SOCK-1:0] prev;
    } ev_st_t;

    ev_st_t st_d, st_q;
    logic [PINS_PER_SOCK-1:0] edge_w;
    logic                     agree_w;

    always_comb begin
        st_d.prev = pins_i;
        edge_w    = pins_i ^ st_q.prev;
        agree_w   = (pins_i[P_CD1] == pins_i[P_CD2]);
        set_o     = '0;
        for (int p = 0; p < PINS_PER_SOCK; p++) begin
            if (p == P_CD1 || p == P_CD2) set_o[B_PIN+p] = edge_w[p] & agree_w;
            else                          set_o[B_PIN+p] = edge_w[p];
        end
        set_o[B_RRISE] = edge_w[P_RDY] &  pins_i[P_RDY];
        set_o[B_RFALL] = edge_w[P_RDY] & ~pins_i[P_RDY];

        live_o          = '0;
        live_o[B_RLOW]  = ~pins_i[P_RDY];
        live_o[B_RHIGH] =  pins_i[P_RDY];

        pinview_o = {pins_i, {(HALF_W-PINS_PER_SOCK){1'b0}}};
        present_o = ~pins_i[P_CD1] & ~pins_i[P_CD2];
        rdy_low_o = ~pins_i[P_RDY];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/csi_regs.sv
module csi_regs
    import csi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_W-1:0]     set_i,
    input  logic                 we_i,
    input  logic [1:0]           addr_i,
    input  logic [MAX_SOCK-1:0]  hsel_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     stat_o,
    output logic [REG_W-1:0]     en_o
);
    localparam logic [REG_W-1:0] LATCH_MASK = {MAX_SOCK{HALF_LATCH}};

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] en;
    } reg_st_t;

    reg_st_t          st_d, st_q;
    logic [REG_W-1:0] hmask;
    logic [REG_W-1:0] clr;

    always_comb begin
        for (int h = 0; h < MAX_SOCK; h++) begin
            hmask[h*HALF_W +: HALF_W] = {HALF_W{hsel_i[h]}};
        end
        clr  = '0;
        st_d = st_q;
        if (we_i && addr_i == A_STAT) clr = wdata_i & hmask;
        // a set arriving in the same cycle as a clear wins
        st_d.stat = ((st_q.stat & ~clr) | set_i) & LATCH_MASK;
        if (we_i && addr_i == A_EN) st_d.en = (st_q.en & ~hmask) | (wdata_i & hmask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
endmodule

// File: rtl/card_status_irq.sv
module card_status_irq
    import csi_pkg::*;
#(
    parameter int NUM_SOCK = 2   // 1 or 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SOCK*PINS_PER_SOCK-1:0] sock_pins_i,
    input  logic                              bus_we,
    input  logic [1:0]                        bus_addr,
    input  logic [1:0]                        bus_hsel,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              sc_irq_o,
    output logic [NUM_SOCK-1:0]               card_irq_o,
    output logic [NUM_SOCK-1:0]               card_present_o
);
    localparam int PW      = NUM_SOCK * PINS_PER_SOCK;
    localparam int UNUSED  = HALF_W * (MAX_SOCK - NUM_SOCK);
    localparam logic [REG_W-1:0] LOW_MASK = {MAX_SOCK{HALF_LOW}};

    logic [PW-1:0]    pins_sync;
    logic [REG_W-1:0] set_vec, live_vec, pin_view;
    logic [REG_W-1:0] stat_latched, enable_w, stat_view;
    logic [NUM_SOCK-1:0] rdy_low;

    csi_sync #(.W(PW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sock_pins_i),
        .sync_o (pins_sync)
    );

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        localparam int LSB = REG_W - HALF_W * (s + 1);
        csi_sock_events u_ev (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_i    (pins_sync[s*PINS_PER_SOCK +: PINS_PER_SOCK]),
            .set_o     (set_vec[LSB +: HALF_W]),
            .live_o    (live_vec[LSB +: HALF_W]),
            .pinview_o (pin_view[LSB +: HALF_W]),
            .present_o (card_present_o[s]),
            .rdy_low_o (rdy_low[s])
        );
        assign card_irq_o[s] = enable_w[LSB + B_RLOW] & rdy_low[s];
    end

    if (UNUSED > 0) begin : g_unused
        assign set_vec[UNUSED-1:0]  = '0;
        assign live_vec[UNUSED-1:0] = '0;
        assign pin_view[UNUSED-1:0] = '0;
    end

    csi_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .hsel_i  (bus_hsel),
        .wdata_i (bus_wdata),
        .stat_o  (stat_latched),
        .en_o    (enable_w)
    );

    assign stat_view = stat_latched | live_vec;
    assign sc_irq_o  = |(stat_view & enable_w & ~LOW_MASK);

    always_comb begin
        case (bus_addr)
            A_PINS:  bus_rdata = pin_view;
            A_STAT:  bus_rdata = stat_view;
            A_EN:    bus_rdata = enable_w;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/csi_checker.sv
module csi_checker
    import csi_pkg::*;
#(
    parameter int NUM_SOCK = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              bus_we,
    input logic [1:0]                        bus_addr,
    input logic [1:0]                        bus_hsel,
    input logic [REG_W-1:0]                  stat_q,
    input logic [REG_W-1:0]                  en_q,
    input logic [NUM_SOCK*PINS_PER_SOCK-1:0] pins_s,
    input logic [NUM_SOCK-1:0]               card_irq
);
    // R5: latched bits only drop through a write to the change register
    p_no_silent_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6: an unselected upper half of the enable register holds
    p_half_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN && !bus_hsel[1]) |=> (en_q[31:16] == $past(en_q[31:16])));

    // R4: socket 0 detect-1 change recorded only with agreeing detect pins
    p_cd_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[REG_W-HALF_W+B_PIN+P_CD1]) |-> $past(pins_s[P_CD1] == pins_s[P_CD2]));

    // R3: socket 0 ready-rose flag follows a high ready pin
    p_rise_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[REG_W-HALF_W+B_RRISE]) |-> $past(pins_s[P_RDY]));

    // R8: socket 0 card interrupt only while its ready pin is low
    p_card_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq[0] |-> !pins_s[P_RDY]);
endmodule

bind card_status_irq csi_checker #(.NUM_SOCK(NUM_SOCK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_hsel (bus_hsel),
    .stat_q   (stat_latched),
    .en_q     (enable_w),
    .pins_s   (pins_sync),
    .card_irq (card_irq_o)
);

// File: tb/card_status_irq_tb.sv
`timescale 1ns/1ps
module card_status_irq_tb;
    localparam int NS = 2;
    localparam logic [31:0] LOWM = 32'h0080_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [1:0]  bus_hsel = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sc_irq;
    logic [1:0]  card_irq, card_present;

    always #2.5 clk = ~clk;

    card_status_irq #(.NUM_SOCK(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sock_pins_i(pins),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_hsel(bus_hsel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sc_irq_o(sc_irq), .card_irq_o(card_irq), .card_present_o(card_present)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_en   = '0;
    logic [15:0] m_pins = '0;

    function automatic int hl(int s);
        return 16 - 16 * s;
    endfunction

    function automatic logic [31:0] f_pinview();
        logic [31:0] v = '0;
        for (int s = 0; s < NS; s++) v[hl(s)+8 +: 8] = m_pins[s*8 +: 8];
        return v;
    endfunction

    function automatic logic [31:0] f_view();
        logic [31:0] v = m_stat;
        for (int s = 0; s < NS; s++) begin
            v[hl(s)+7] = ~m_pins[s*8];
            v[hl(s)+6] =  m_pins[s*8];
        end
        return v;
    endfunction

    function automatic logic f_sc();
        return |(f_view() & m_en & ~LOWM);
    endfunction

    function automatic logic [1:0] f_card();
        logic [1:0] v;
        for (int s = 0; s < NS; s++) v[s] = m_en[hl(s)+7] & ~m_pins[s*8];
        return v;
    endfunction

    function automatic logic [1:0] f_pres();
        logic [1:0] v;
        for (int s = 0; s < NS; s++) v[s] = ~m_pins[s*8+3] & ~m_pins[s*8+4];
        return v;
    endfunction

    // records the edges of a pin change in the model
    function automatic void m_edges(logic [15:0] nw);
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 8; p++) begin
                if (nw[s*8+p] != m_pins[s*8+p]) begin
                    if (p == 3 || p == 4) begin
                        if (nw[s*8+3] == nw[s*8+4]) m_stat[hl(s)+8+p] = 1'b1;
                    end else begin
                        m_stat[hl(s)+8+p] = 1'b1;
                    end
                    if (p == 0) m_stat[hl(s) + (nw[s*8] ? 5 : 4)] = 1'b1;
                end
            end
        end
        m_pins = nw;
    endfunction

    function automatic void m_write(logic [1:0] a, logic [1:0] hs, logic [31:0] d);
        logic [31:0] hm = {{16{hs[1]}}, {16{hs[0]}}};
        if (a == 2'd1) m_stat = m_stat & ~(d & hm) & 32'hFF30_FF30;
        if (a == 2'd2) m_en = (m_en & ~hm) | (d & hm);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] hs, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_hsel = hs; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        m_write(a, hs, d);
    endtask

    task automatic apply_pins(logic [15:0] nw);
        @(negedge clk);
        pins = nw;
        repeat (4) @(posedge clk);
        m_edges(nw);
    endtask

    task automatic check_all(string ctx);
        logic [31:0] d;
        rd(2'd0, d); check({ctx, " R2 pin register"}, d, f_pinview());
        rd(2'd1, d); check({ctx, " R3 change register"}, d, f_view());
        rd(2'd2, d); check({ctx, " R6 enable register"}, d, m_en);
        check({ctx, " R7 sc_irq"}, {31'd0, sc_irq}, {31'd0, f_sc()});
        check({ctx, " R8 card_irq"}, {30'd0, card_irq}, {30'd0, f_card()});
        check({ctx, " R9 card_present"}, {30'd0, card_present}, {30'd0, f_pres()});
        rd(2'd3, d); check({ctx, " R10 unused address"}, d, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        rd(2'd1, d); check("R1 change register after reset", d, 32'h0080_0080);
        rd(2'd2, d); check("R1 enable after reset", d, 32'h0);
        check("R1 irqs low", {29'd0, sc_irq, card_irq}, 32'd0);

        // R6: upper half only
        wr(2'd2, 2'b10, 32'hFFFF_FFFF);
        check_all("R6 upper-half enable");

        // R3/R8: socket 0 ready rises
        apply_pins(16'h0001);
        check_all("R3 ready rise");

        // R4: detect disagreement then agreement on socket 0
        apply_pins(16'h0009);
        check_all("R4 detect disagree");
        apply_pins(16'h0019);
        check_all("R4 detect agree");

        // R5: clear detect-2 bit only, then a zero write
        wr(2'd1, 2'b11, 32'h1000_0000);
        check_all("R5 clear one bit");
        wr(2'd1, 2'b11, 32'h0);
        check_all("R5 zero write");

        // R5: set and clear on the same edge; set wins
        @(negedge clk);
        pins = m_pins ^ 16'h8000;
        repeat (2) @(posedge clk);
        wr(2'd1, 2'b11, 32'h0000_8000);
        repeat (2) @(posedge clk);
        m_edges(m_pins ^ 16'h8000);
        check_all("R5 set wins over clear");

        // R10: writes to pin and unused address have no effect
        wr(2'd0, 2'b11, 32'hFFFF_FFFF);
        wr(2'd3, 2'b11, 32'hFFFF_FFFF);
        check_all("R10 ignored writes");

        // R2: voltage-sense field 1 on socket 0
        apply_pins((m_pins & 16'hFF3F) | 16'h0040);
        rd(2'd0, d); check("R2 voltage-sense field", {30'd0, d[31:30]}, 32'd1);

        // random mix
        for (int it = 0; it < 150; it++) begin
            int unsigned r = $urandom % 3;
            if (r == 0)      apply_pins(m_pins ^ 16'($urandom & $urandom));
            else if (r == 1) wr(2'd1, 2'($urandom), $urandom);
            else             wr(2'd2, 2'($urandom), $urandom);
            check_all("random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule